// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system read and write an external asynchronous static RAM of 128K bytes. Accesses use a single-beat valid/ready handshake. A caller raises `req` with `wr`, `addr` and `wdata`, and holds them until `ready` is high at a rising clock edge. The controller then runs one memory cycle. It finishes with a one-clock `ack` pulse. For a read, `rdata` holds the byte captured from the bus, and it is valid with that pulse.

Every phase length is a whole number of clock ticks. Each one comes from a nanosecond minimum and the clock-frequency parameter, rounded up. After reset the controller refuses all requests for a power-up interval. Between accesses it parks the memory in standby with chip enable high. Writes keep output enable high. The data drivers are switched on only one float interval after write enable has fallen, and they switch off in the same cycle that write enable rises. As a result, the controller and the memory never drive the shared data lines at the same time.

Top module: `sram_ctl`

## Requirements
- R1: After reset is released, `ready` stays low for exactly PWRUP_US x CLK_MHZ clock edges and is high at the edge after that count; 100 us at 50 MHz gives 5000 edges.
- R2: With no access in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 and `mem_drive` is 0.
- R3: A read (`wr`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for N_RD cycles, where N_RD is the larger of the rounded-up access and read-cycle minimums. The byte on `mem_din` in the last of those cycles then appears on `rdata`, in the same cycle as `ack`.
- R4: A write (`wr`=1) holds `mem_ce_n`=0 and `mem_we_n`=0 with `mem_oe_n`=1 for N_WLOW cycles. N_WLOW is the largest of: the write-enable pulse, the address-to-end time, the write-cycle time, and the float time plus the data setup time. While the drivers are on, `mem_dout` equals the requested `wdata`.
- R5: `mem_drive` is 1 only while `mem_we_n`=0 and `mem_oe_n`=1. It stays 0 for the first N_HZ (float time) cycles of write-enable low, and it is 0 again in the cycle in which `mem_we_n` returns to 1.
- R6: `mem_addr` equals the accepted `addr` and does not change while `mem_ce_n` is 0.
- R7: `ready` is 0 while an access is in progress. A `req` that arrives while `ready` is 0 starts no memory cycle until `ready` returns.
- R8: Every access ends with `ack`=1 for exactly one cycle. In that cycle chip enable is already high.
- R9: If `req` is held across an access, the next access starts after exactly one cycle with `mem_ce_n`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | 1 | Access request, held until accepted |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Byte to write |
| ready | output | 1 | Request is accepted at this edge if `req` is high |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 17 | Memory address bus |
| mem_dout | output | 8 | Data toward the memory |
| mem_din | input | 8 | Data from the memory |
| mem_drive | output | 1 | Enables the controller's data drivers |

## Verification
Writes and reads are issued to the lowest and highest addresses and to addresses in between. The data bytes are all-zeros, all-ones and two alternating patterns, so a stuck or swapped data bit shows up as a wrong byte on read-back. Overwriting one location separates a real store from a stale capture, and reading a location that was never written shows that no value leaks from the previous read. Holding the request across an access checks the single standby gap. A request raised during the power-up wait shows that early requests are ignored.

// File: rtl/sram_ctl_pkg.sv
// Shared types and helpers for the SRAM access controller.
// Assumes all timing minimums are given in whole nanoseconds.
package sram_ctl_pkg;

    // Sequencer phases; IDLE keeps the memory in standby.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WPRE = 2'd1,
        PH_WDRV = 2'd2,
        PH_READ = 2'd3
    } phase_e;

    // Round a nanosecond minimum up to whole clock ticks, at least one.
    function automatic int ns_to_ticks(input int ns, input int mhz);
        int t;
        t = (ns * mhz + 999) / 1000;
        return (t < 1) ? 1 : t;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_pwrup_timer.sv
// Power-up hold-off timer: counts clock edges from reset release and
// raises done after TICKS edges. Assumes TICKS >= 1.
module sram_pwrup_timer #(
    parameter int TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    // Count until the last tick, then latch done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            cnt  <= cnt + 1'b1;
            done <= (cnt == LAST);
        end
    end
endmodule

// File: rtl/sram_ctl_fsm.sv
// Phase sequencer: steps through the write (float wait, then driven
// data) or read phases, each held for a fixed tick count.
// Assumes start is asserted only in PH_IDLE.
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int N_WPRE = 1,
    parameter int N_WDRV = 1,
    parameter int N_RD   = 1
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   start_wr,
    output phase_e phase,
    output logic   rd_last,
    output logic   wr_last
);
    localparam int MAXN = max2(max2(N_WPRE, N_WDRV), N_RD);
    localparam int CW   = $clog2(MAXN + 1);

    logic [CW-1:0] cnt;
    logic          phase_end;

    // Decode whether the current phase is in its final tick.
    always_comb begin
        unique case (phase)
            PH_WPRE: phase_end = (cnt == CW'(N_WPRE - 1));
            PH_WDRV: phase_end = (cnt == CW'(N_WDRV - 1));
            PH_READ: phase_end = (cnt == CW'(N_RD - 1));
            default: phase_end = 1'b0;
        endcase
    end

    assign rd_last = (phase == PH_READ) && phase_end;
    assign wr_last = (phase == PH_WDRV) && phase_end;

    // Advance phase and phase tick counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= start_wr ? PH_WPRE : PH_READ;
                end
                PH_WPRE: begin
                    cnt <= phase_end ? '0 : cnt + 1'b1;
                    if (phase_end) phase <= PH_WDRV;
                end
                default: begin
                    cnt <= phase_end ? '0 : cnt + 1'b1;
                    if (phase_end) phase <= PH_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_ctl_dpath.sv
// Datapath: holds the accepted address and write byte, captures read
// data on the final read tick and produces the completion pulse.
module sram_ctl_dpath #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          rd_last,
    input  logic          wr_last,
    input  logic [DW-1:0] bus_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rdata_q,
    output logic          ack_q
);
    // Latch request fields when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    // Capture the read byte and pulse completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            ack_q   <= 1'b0;
        end else begin
            ack_q <= rd_last || wr_last;
            if (rd_last) rdata_q <= bus_in;
        end
    end
endmodule

// File: rtl/sram_ctl.sv
// Top of the asynchronous SRAM access controller. Converts nanosecond
// minimums into tick counts for CLK_MHZ, gates requests behind the
// power-up timer and decodes the active-low memory strobes from the phase.
// Assumes req and its fields are held stable until accepted.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_MHZ  = 50,
    parameter int PWRUP_US = 100,
    parameter int AW       = 17,
    parameter int DW       = 8,
    parameter int TAA_NS   = 10,
    parameter int TRC_NS   = 10,
    parameter int TWC_NS   = 10,
    parameter int TPWE_NS  = 7,
    parameter int TSD_NS   = 5,
    parameter int TAW_NS   = 8,
    parameter int THZ_NS   = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          ack,
    output logic [DW-1:0] rdata,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_dout,
    input  logic [DW-1:0] mem_din,
    output logic          mem_drive
);
    localparam int PWR_TICKS = PWRUP_US * CLK_MHZ;
    localparam int N_HZ      = ns_to_ticks(THZ_NS, CLK_MHZ);
    localparam int N_SD      = ns_to_ticks(TSD_NS, CLK_MHZ);
    localparam int N_WLOW    = max2(max2(ns_to_ticks(TPWE_NS, CLK_MHZ),
                                         ns_to_ticks(TAW_NS, CLK_MHZ)),
                                    max2(ns_to_ticks(TWC_NS, CLK_MHZ),
                                         N_HZ + N_SD));
    localparam int N_RD      = max2(ns_to_ticks(TAA_NS, CLK_MHZ),
                                    ns_to_ticks(TRC_NS, CLK_MHZ));

    logic   pwr_ok;
    logic   start;
    logic   rd_last;
    logic   wr_last;
    phase_e phase;

    sram_pwrup_timer #(.TICKS(PWR_TICKS)) u_pwr (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_ok)
    );

    assign ready = pwr_ok && (phase == PH_IDLE);
    assign start = ready && req;

    sram_ctl_fsm #(
        .N_WPRE (N_HZ),
        .N_WDRV (N_WLOW - N_HZ),
        .N_RD   (N_RD)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_wr (wr),
        .phase    (phase),
        .rd_last  (rd_last),
        .wr_last  (wr_last)
    );

    sram_ctl_dpath #(.AW(AW), .DW(DW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .addr_in  (addr),
        .wdata_in (wdata),
        .rd_last  (rd_last),
        .wr_last  (wr_last),
        .bus_in   (mem_din),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dout),
        .rdata_q  (rdata),
        .ack_q    (ack)
    );

    // Decode memory strobes and driver enable from the phase.
    always_comb begin
        mem_ce_n  = (phase == PH_IDLE);
        mem_oe_n  = (phase != PH_READ);
        mem_we_n  = !((phase == PH_WPRE) || (phase == PH_WDRV));
        mem_drive = (phase == PH_WDRV);
    end
endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for sram_ctl, attached by bind below.
module sram_ctl_chk #(
    parameter int AW = 17
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ready,
    input logic          ack,
    input logic          mem_ce_n,
    input logic          mem_oe_n,
    input logic          mem_we_n,
    input logic          mem_drive,
    input logic [AW-1:0] mem_addr
);
    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_drive |-> (!mem_we_n && mem_oe_n && !mem_ce_n)); // R5
    AST_FLOAT_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_drive); // R5
    AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n); // R4
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R6
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
    AST_ACK_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> mem_ce_n); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> !ready); // R7
    AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (mem_oe_n && mem_we_n && !mem_drive)); // R2
endmodule

bind sram_ctl sram_ctl_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ready     (ready),
    .ack       (ack),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_drive (mem_drive),
    .mem_addr  (mem_addr)
);

// File: tb/sram_ctl_test.sv
// Directed bench for sram_ctl with a behavioural byte memory.
module sram_ctl_test;
    localparam int MHZ   = 50;
    localparam int PWR   = 100 * MHZ;
    localparam int N_HZ  = 1;  // 5 ns at 20 ns per tick
    localparam int N_WLW = 1 + 1; // max(7,8,10 ns -> 1 tick, float + setup = 2)
    localparam int N_RD  = 1;  // 10 ns rounded up

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ready, ack;
    logic [7:0]  rdata;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_drive;
    logic [16:0] mem_addr;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    logic [7:0] mem [int];

    always #10 clk = ~clk;

    sram_ctl uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .ready(ready), .ack(ack), .rdata(rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_drive(mem_drive)
    );

    // Memory model: store on clock while selected, write-enabled and driven.
    always @(posedge clk)
        if (!mem_ce_n && !mem_we_n && mem_drive) mem[int'(mem_addr)] = mem_dout;

    // Memory model: drive read data only when read-selected.
    always_comb begin
        mem_din = 8'h00;
        if (!mem_ce_n && !mem_oe_n && mem_we_n && mem.exists(int'(mem_addr)))
            mem_din = mem[int'(mem_addr)];
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic test_powerup();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", ready, 0);
        chk("R2 idle strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_drive}, 4'b1110);
        rst_n = 1'b1;
        req = 1'b1; wr = 1'b0; addr = 17'h00123;
        for (int k = 1; k <= PWR; k++) begin
            @(negedge clk);
            if (k == 10 || k == PWR - 1) begin
                chk("R1 ready during wait", ready, 0);
                chk("R7 no access during wait", mem_ce_n, 1);
            end
        end
        req = 1'b0;
        chk("R1 ready at end of wait", ready, 1);
        @(negedge clk);
        chk("R7 early request left no cycle", mem_ce_n, 1);
    endtask

    task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit hold);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        if (!hold) req = 1'b0;
        for (int i = 0; i < N_WLW; i++) begin
            chk("R4 write strobes", {mem_ce_n, mem_oe_n, mem_we_n}, 3'b010);
            chk("R5 driver timing", mem_drive, (i >= N_HZ));
            chk("R6 write address", mem_addr, a);
            chk("R7 busy", ready, 0);
            if (i >= N_HZ) chk("R4 write data", mem_dout, d);
            @(negedge clk);
        end
        chk("R8 write ack", ack, 1);
        chk("R5 release with WE rise", {mem_we_n, mem_drive, mem_ce_n}, 3'b101);
    endtask

    task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
        while (!ready) @(negedge clk);
        req = 1'b1; wr = 1'b0; addr = a;
        @(negedge clk);
        req = 1'b0;
        for (int i = 0; i < N_RD; i++) begin
            chk("R3 read strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_drive}, 4'b0010);
            chk("R6 read address", mem_addr, a);
            @(negedge clk);
        end
        chk("R8 read ack", ack, 1);
        chk("R3 read data", rdata, exp);
        @(negedge clk);
        chk("R8 ack single", ack, 0);
        chk("R2 idle after read", {mem_ce_n, mem_oe_n, mem_we_n, mem_drive}, 4'b1110);
    endtask

    task automatic test_back_to_back();
        do_write(17'h00444, 8'h3C, 1'b1);
        // ack cycle is the single standby cycle; request re-accepted here
        chk("R9 one standby cycle", {mem_ce_n, ready}, 2'b11);
        addr = 17'h00445; wdata = 8'hC3;
        @(negedge clk);
        req = 1'b0;
        chk("R9 next access starts", mem_ce_n, 0);
        chk("R9 next address", mem_addr, 17'h00445);
        while (!ack) @(negedge clk);
        do_read(17'h00444, 8'h3C);
        do_read(17'h00445, 8'hC3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        test_powerup();
        do_write(17'h00000, 8'hA5, 1'b0);
        do_write(17'h1FFFF, 8'h5A, 1'b0);
        do_write(17'h0ABCD, 8'hFF, 1'b0);
        do_write(17'h15432, 8'h00, 1'b0);
        do_read(17'h00000, 8'hA5);
        do_read(17'h1FFFF, 8'h5A);
        do_read(17'h0ABCD, 8'hFF);
        do_read(17'h15432, 8'h00);
        do_write(17'h0ABCD, 8'h96, 1'b0);
        do_read(17'h0ABCD, 8'h96);
        do_read(17'h0F0F0, 8'h00);
        test_back_to_back();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule